// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This block turns one 512-bit message block into the stream of per-round word pairs that an SM3 compression core consumes. For each of the 64 rounds it presents the schedule word W[j] and the companion word W'[j] = W[j] xor W[j+4]. The compression core pulls them one round at a time through a ready handshake.

The block keeps a 16-word sliding window. A load strobe fills the window from the 512-bit input. Every accepted round shifts the window down by one word. The tail entry is then filled with a freshly expanded word. The expansion uses the SM3 recurrence with the P1 permutation. Because the window always holds W[j] through W[j+15], the word four positions ahead is ready in every round. This holds through round 63, which needs W[67].

A one-cycle done pulse marks that the last round has been taken. A new load may be issued at any time and restarts the sequence with the new block.

Top module: `sm3x_msg_expand`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, valid_o is 0, done_o is 0 and round_o is 0.
- R2: The cycle after load_i is sampled high, valid_o is 1 and round_o is 0. The 512-bit block_i is split into sixteen big-endian words, with word 0 = block_i[511:480] and word k = block_i[511-32k -: 32], so w_o shows word 0.
- R3: Each clock edge with valid_o and ready_i both high (an advance) moves round_o up by one. For rounds 0 to 15, w_o equals input word round_o.
- R4: For rounds 16 to 63, w_o equals W[j] = P1(W[j-16] ^ W[j-9] ^ rol(W[j-3],15)) ^ rol(W[j-13],7) ^ W[j-6], where P1(x) = x ^ rol(x,15) ^ rol(x,23) and rol is a 32-bit left rotation.
- R5: In every valid round, wp_o equals W[j] ^ W[j+4]. This includes rounds 60 to 63, which use W[64] to W[67].
- R6: While valid_o is 1 and ready_i is 0 (and no load is applied), round_o, w_o, wp_o and valid_o keep their values on the next cycle.
- R7: An advance taken in round 63 makes valid_o 0, round_o 0 and done_o 1 on the next cycle. done_o returns to 0 one cycle later.
- R8: A load applied during a run, even in the same cycle as an advance, restarts at round 0 with the new block. The advance in that cycle is discarded.
- R9: While valid_o is 0, ready_i has no effect: valid_o and done_o stay 0 until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Block-load strobe |
| block_i | input | 512 | Message block, byte 0 in bits 511:504 |
| ready_i | input | 1 | Consumer takes the current round |
| valid_o | output | 1 | Round outputs are valid |
| round_o | output | 6 | Current round index |
| w_o | output | 32 | Schedule word W[j] |
| wp_o | output | 32 | W[j] xor W[j+4] |
| done_o | output | 1 | One-cycle pulse after round 63 is taken |

## Verification
All results are registered, so each one is due exactly one rising edge after its cause:
- round 0 appears one edge after the load strobe;
- the next round's pair appears one edge after an advance;
- the done pulse appears one edge after round 63 is taken.

The bench changes inputs on the falling edge. It checks the outputs on the following falling edge, which lies halfway after the single edge in which the result was due. An independent model in the bench computes the expected W[0..67] for each block. The blocks are consumed with continuous ready, alternating ready and pseudo-random stalls.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int WORD_W    = 32;
  localparam int WIN_DEPTH = 16;
  localparam int BLOCK_W   = WORD_W * WIN_DEPTH;
  localparam int AHEAD     = 4;
  localparam int P1_ROT_A  = 15;
  localparam int P1_ROT_B  = 23;
  localparam int TAP3_ROT  = 15;
  localparam int TAP13_ROT = 7;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rol(word_t x, int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t p1(word_t x);
    return x ^ rol(x, P1_ROT_A) ^ rol(x, P1_ROT_B);
  endfunction
endpackage

// File: rtl/sm3x_word_gen.sv
module sm3x_word_gen
  import sm3x_pkg::*;
(
  input  word_t t16_i,
  input  word_t t13_i,
  input  word_t t9_i,
  input  word_t t6_i,
  input  word_t t3_i,
  output word_t new_o
);
  word_t mix;

  always_comb begin
    mix   = t16_i ^ t9_i ^ rol(t3_i, TAP3_ROT);
    new_o = p1(mix) ^ rol(t13_i, TAP13_ROT) ^ t6_i;
  end
endmodule

// File: rtl/sm3x_window.sv
module sm3x_window
  import sm3x_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BLOCK_W-1:0] block_i,
  input  logic               shift_i,
  output word_t              win_o [WIN_DEPTH]
);
  // win_q[k] holds W[j+k] for current round j
  word_t win_q  [WIN_DEPTH];
  word_t nxt    [WIN_DEPTH];
  word_t fresh;

  sm3x_word_gen u_gen (
    .t16_i (win_q[0]),
    .t13_i (win_q[3]),
    .t9_i  (win_q[7]),
    .t6_i  (win_q[10]),
    .t3_i  (win_q[13]),
    .new_o (fresh)
  );

  for (genvar k = 0; k < WIN_DEPTH; k++) begin : g_slot
    word_t shifted;
    if (k == WIN_DEPTH - 1) begin : g_tail
      assign shifted = fresh;
    end else begin : g_body
      assign shifted = win_q[k+1];
    end
    assign nxt[k] = load_i  ? block_i[BLOCK_W-1-k*WORD_W -: WORD_W] :
                    shift_i ? shifted : win_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < WIN_DEPTH; k++) win_q[k] <= '0;
    end else begin
      for (int k = 0; k < WIN_DEPTH; k++) win_q[k] <= nxt[k];
    end
  end

  assign win_o = win_q;

  assert_load_head_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> win_o[0] == $past(block_i[BLOCK_W-1 -: WORD_W]));

  assert_tail_append_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> win_o[WIN_DEPTH-1] == $past(fresh));
endmodule

// File: rtl/sm3x_round_ctrl.sv
module sm3x_round_ctrl #(
  parameter int NUM_ROUNDS = 64,
  localparam int RND_W = $clog2(NUM_ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [RND_W-1:0] round_o,
  output logic             done_o,
  output logic             shift_o
);
  localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS - 1);

  logic             valid_q, done_q;
  logic [RND_W-1:0] round_q;
  logic             adv, at_last;

  assign adv     = valid_q && ready_i;
  assign at_last = round_q == LAST;
  assign shift_o = adv && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      round_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= shift_o && at_last;
      if (load_i) begin
        valid_q <= 1'b1;
        round_q <= '0;
      end else if (adv) begin
        if (at_last) begin
          valid_q <= 1'b0;
          round_q <= '0;
        end else begin
          round_q <= round_q + RND_W'(1);
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign round_o = round_q;
  assign done_o  = done_q;

  assert_load_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (valid_o && round_o == '0 && !done_o));

  assert_round_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !load_i && round_o != LAST) |=>
      (valid_o && round_o == $past(round_o) + RND_W'(1)));

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(round_o)));

  assert_finish_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !load_i && round_o == LAST) |=>
      (done_o && !valid_o && round_o == '0));

  assert_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  assert_idle_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !load_i) |=> (!valid_o && !done_o));
endmodule

// File: rtl/sm3x_msg_expand.sv
module sm3x_msg_expand
  import sm3x_pkg::*;
#(
  parameter int NUM_ROUNDS = 64,
  localparam int RND_W = $clog2(NUM_ROUNDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BLOCK_W-1:0] block_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [RND_W-1:0]   round_o,
  output logic [WORD_W-1:0]  w_o,
  output logic [WORD_W-1:0]  wp_o,
  output logic               done_o
);
  logic  shift;
  word_t win [WIN_DEPTH];

  sm3x_round_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .ready_i (ready_i),
    .valid_o (valid_o),
    .round_o (round_o),
    .done_o  (done_o),
    .shift_o (shift)
  );

  sm3x_window u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .block_i (block_i),
    .shift_i (shift),
    .win_o   (win)
  );

  assign w_o  = win[0];
  assign wp_o = win[0] ^ win[AHEAD];

  assert_stall_words_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i) |=> ($stable(w_o) && $stable(wp_o)));

  assert_shift_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !load_i) |=> w_o == $past(win[1]));

  assert_pair_ahead_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !load_i) |=> (wp_o ^ w_o) == $past(win[AHEAD+1]));
endmodule

// File: tb/sm3x_msg_expand_bench.sv
module sm3x_msg_expand_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [511:0] block_i = '0;
  logic         ready_i = 1'b0;
  logic         valid_o, done_o;
  logic [5:0]   round_o;
  logic [31:0]  w_o, wp_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [31:0] exp_w [0:67];
  logic [15:0] lfsr = 16'hace1;

  always #4 clk_i = ~clk_i;

  sm3x_msg_expand u_sm3x_msg_expand (
    .clk_i, .rst_ni, .load_i, .block_i, .ready_i,
    .valid_o, .round_o, .w_o, .wp_o, .done_o
  );

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    logic [63:0] d = {x, x};
    return d[63-n -: 32];
  endfunction

  task automatic build_ref(input logic [511:0] blk);
    for (int i = 0; i < 16; i++) exp_w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 68; i++) begin
      logic [31:0] s;
      s = exp_w[i-16] ^ exp_w[i-9] ^ rl(exp_w[i-3], 15);
      exp_w[i] = (s ^ rl(s, 15) ^ rl(s, 23)) ^ rl(exp_w[i-13], 7) ^ exp_w[i-6];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // mode 0: always ready, 1: alternate, 2: pseudo-random stalls
  task automatic run_block(input logic [511:0] blk, input int mode);
    int j = 0;
    int n = 0;
    build_ref(blk);
    @(negedge clk_i);
    load_i = 1'b1; block_i = blk; ready_i = 1'b0;
    @(negedge clk_i);
    load_i = 1'b0;
    chk("R2 valid", 32'(valid_o), 1);
    while (j < 64) begin
      logic rdy;
      chk("R3 round", 32'(round_o), 32'(j));
      chk(j < 16 ? "R3 word" : "R4 word", w_o, exp_w[j]);
      chk("R5 pair", wp_o, exp_w[j] ^ exp_w[j+4]);
      chk("R6 valid held", 32'(valid_o), 1);
      case (mode)
        0: rdy = 1'b1;
        1: rdy = n[0];
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          rdy = lfsr[0];
        end
      endcase
      n++;
      ready_i = rdy;
      @(negedge clk_i);
      if (rdy) j++;
    end
    ready_i = 1'b0;
    chk("R7 done", 32'(done_o), 1);
    chk("R7 valid low", 32'(valid_o), 0);
    chk("R7 round zero", 32'(round_o), 0);
    @(negedge clk_i);
    chk("R7 done pulse", 32'(done_o), 0);
  endtask

  initial begin
    logic [511:0] b_zero, b_ones, b_cnt, b_abc, b_mix;
    b_zero = '0;
    b_ones = '1;
    for (int i = 0; i < 64; i++) b_cnt[511-8*i -: 8] = 8'(i);
    b_abc = '0;
    b_abc[511 -: 32] = 32'h61626380;
    b_abc[31:0] = 32'h00000018;
    for (int i = 0; i < 16; i++) b_mix[511-32*i -: 32] = 32'(i + 1) * 32'h9e3779b9;

    repeat (3) @(negedge clk_i);
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 round", 32'(round_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid after release", 32'(valid_o), 0);
    chk("R1 round after release", 32'(round_o), 0);

    // R9: ready while idle
    ready_i = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      chk("R9 valid", 32'(valid_o), 0);
      chk("R9 done", 32'(done_o), 0);
    end
    ready_i = 1'b0;

    run_block(b_abc, 0);
    run_block(b_zero, 0);
    run_block(b_ones, 1);
    run_block(b_cnt, 2);
    run_block(b_mix, 2);

    // R8: reload mid-run, together with an advance
    build_ref(b_cnt);
    load_i = 1'b1; block_i = b_cnt;
    @(negedge clk_i);
    load_i = 1'b0; ready_i = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R8 mid round", 32'(round_o), 10);
    chk("R8 mid word", w_o, exp_w[10]);
    load_i = 1'b1; block_i = b_mix;
    @(negedge clk_i);
    load_i = 1'b0; ready_i = 1'b0;
    build_ref(b_mix);
    chk("R8 restart round", 32'(round_o), 0);
    chk("R8 restart valid", 32'(valid_o), 1);
    chk("R8 restart word", w_o, exp_w[0]);
    chk("R8 restart pair", wp_o, exp_w[0] ^ exp_w[4]);
    chk("R8 no done", 32'(done_o), 0);
    run_block(b_mix, 1);

    // R9: ready after finish has no effect
    ready_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk("R9 valid after done", 32'(valid_o), 0);
      chk("R9 done after done", 32'(done_o), 0);
    end
    ready_i = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule